// File: doc/BRIEF.md
# PLL Lock Detector with Programmable Observation Window

This block decides whether a phase-locked loop has settled. It watches two pulse streams that share the reference-oscillator clock: the divided reference and the divided VCO feedback. It pairs each rising edge of one stream with the next rising edge of the other. A pair counts as aligned when the two edges fall no more than a fixed tolerance of oscillator cycles apart. A free-running window counter measures how long the loop has gone without a misaligned pair. The lock flag rises only when the counter spans a whole window.

The window is a power of two in oscillator cycles. Its exponent is a 3-bit field of an 8-bit configuration byte plus a fixed offset of 13. The window can therefore run from 2^13 to 2^20 cycles. A window should cover the reference divide ratio times the number of comparisons needed to resolve the residual frequency error the loop may keep, which is about 1 kHz. The field is chosen as the ceiling of log2 of that product, minus 13. For example, a field value of 6 gives a window of 2^19 cycles.

Any misaligned pair restarts the window and drops lock. A write that changes the field does the same. After that, lock must be earned again over a full window.

Top module: `pll_lock_detector`

## Requirements
- R1: While `rst_ni` is low, `lock_o` is 0 at once, without waiting for a clock edge. Reset also loads the window field with its reset value of 6, so after reset, lock cannot appear sooner than 2^19 cycles.
- R2: The window field is `cfg_i[7:5]`, captured when `cfg_we_i` is high. With field value M, `lock_o` rises exactly 2^(M+13) clock edges after the edge that last cleared the window. That clearing edge is either the reset release or a clearing event.
- R3: A rising edge on one stream is accepted when the partner stream's rising edge arrives at most TOL cycles later (TOL = 2), in either order, or in the same cycle. An accepted pair does not disturb the window.
- R4: If no partner edge arrives within TOL cycles after an edge, the pair is misaligned. A partner edge that arrives exactly TOL+1 cycles later counts as misaligned and is consumed. `lock_o` falls after the edge TOL+2 cycles after the lone edge was sampled.
- R5: A second rising edge of the same stream, before its partner has arrived, is a misalignment. `lock_o` falls one edge after that second edge is sampled.
- R6: A write with `cfg_we_i` high whose `cfg_i[7:5]` differs from the stored field clears the window and drops `lock_o` at that edge. The new window length applies from then on.
- R7: A write whose `cfg_i[7:5]` equals the stored field has no effect on `lock_o` or on the window, whatever the other bits of `cfg_i` hold.
- R8: Once asserted, `lock_o` stays high for as long as no misalignment and no field change occur.
- R9: Only rising edges count. A pulse held high for several cycles counts as one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference-oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | Divided reference pulse stream |
| fb_pulse_i | input | 1 | Divided VCO feedback pulse stream |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_i | input | 8 | Configuration byte; bits [7:5] hold the window exponent field |
| lock_o | output | 1 | Lock indicator |

## Verification
The window state shows at the port in two ways. The lock flag can rise too early or too late relative to the last clearing edge. It can also stay up after a misalignment that should have restarted the window. The bench therefore compares `lock_o` on every clock against a model that tracks pending edges and quiet time, so a pairing fault shows within TOL+2 cycles of the offending edge. A wrong field capture, or a wrong exponent offset, appears as a rise time that is off by a power of two. A wrongly kept edge-detector state appears as a false misalignment on wide pulses.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_WAIT_FB  = 2'd1,
    PH_WAIT_REF = 2'd2
  } ph_state_e;

  localparam int unsigned NUM_STREAMS = 2;
  localparam int unsigned IDX_REF     = 0;
  localparam int unsigned IDX_FB      = 1;
endpackage

// File: rtl/lockdet_edge.sv
module lockdet_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/lockdet_phase.sv
module lockdet_phase
  import lockdet_pkg::*;
#(
  parameter int unsigned TOL = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic fb_rise_i,
  output logic miss_o
);
  localparam int unsigned GAP_W = $clog2(TOL + 2);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(TOL);

  ph_state_e        state_q, state_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             miss_q, miss_d;
  logic             own_rise, other_rise;

  // own = stream that opened the pair, other = awaited partner
  always_comb begin
    own_rise   = (state_q == PH_WAIT_FB) ? ref_rise_i : fb_rise_i;
    other_rise = (state_q == PH_WAIT_FB) ? fb_rise_i  : ref_rise_i;
  end

  always_comb begin
    state_d = state_q;
    gap_d   = gap_q;
    miss_d  = 1'b0;
    unique case (state_q)
      PH_IDLE: begin
        if (ref_rise_i && !fb_rise_i) begin
          state_d = PH_WAIT_FB;
          gap_d   = '0;
        end else if (fb_rise_i && !ref_rise_i) begin
          state_d = PH_WAIT_REF;
          gap_d   = '0;
        end
      end
      PH_WAIT_FB, PH_WAIT_REF: begin
        if (own_rise || gap_q == GAP_LIM) begin
          miss_d  = 1'b1;
          state_d = PH_IDLE;
        end else if (other_rise) begin
          state_d = PH_IDLE;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      gap_q   <= '0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      gap_q   <= gap_d;
      miss_q  <= miss_d;
    end
  end

  assign miss_o = miss_q;
endmodule

// File: rtl/lockdet_window.sv
module lockdet_window #(
  parameter int unsigned FIELD_W    = 3,
  parameter int unsigned EXP_OFFSET = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [FIELD_W-1:0] exp_i,
  output logic               lock_o
);
  localparam int unsigned CNT_W = EXP_OFFSET + (1 << FIELD_W);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] win_last;
  logic             lock_q;

  assign win_last = (CNT_ONE << (32'(exp_i) + EXP_OFFSET)) - CNT_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else if (!lock_q) begin
      cnt_q <= cnt_q + CNT_ONE;
      if (cnt_q == win_last) lock_q <= 1'b1;
    end
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/pll_lock_detector.sv
module pll_lock_detector
  import lockdet_pkg::*;
#(
  parameter int unsigned CFG_W      = 8,
  parameter int unsigned FIELD_LSB  = 5,
  parameter int unsigned FIELD_W    = 3,
  parameter int unsigned EXP_OFFSET = 13,
  parameter int unsigned TOL        = 2,
  parameter logic [CFG_W-1:0] CFG_RST = 8'hC0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ref_pulse_i,
  input  logic             fb_pulse_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             lock_o
);
  localparam logic [FIELD_W-1:0] FIELD_RST = CFG_RST[FIELD_LSB +: FIELD_W];

  logic [FIELD_W-1:0]     m_q;
  logic [FIELD_W-1:0]     field_new_w;
  logic                   field_chg_w;
  logic [NUM_STREAMS-1:0] lvl_w;
  logic [NUM_STREAMS-1:0] rise_w;
  logic                   miss_w;
  logic                   clr_w;

  assign field_new_w = cfg_i[FIELD_LSB +: FIELD_W];
  assign field_chg_w = cfg_we_i && (field_new_w != m_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       m_q <= FIELD_RST;
    else if (cfg_we_i) m_q <= field_new_w;
  end

  assign lvl_w[IDX_REF] = ref_pulse_i;
  assign lvl_w[IDX_FB]  = fb_pulse_i;

  for (genvar gi = 0; gi < NUM_STREAMS; gi++) begin : g_edge
    lockdet_edge u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl_w[gi]),
      .rise_o (rise_w[gi])
    );
  end

  lockdet_phase #(.TOL(TOL)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_rise_i (rise_w[IDX_REF]),
    .fb_rise_i  (rise_w[IDX_FB]),
    .miss_o     (miss_w)
  );

  assign clr_w = miss_w | field_chg_w;

  lockdet_window #(
    .FIELD_W    (FIELD_W),
    .EXP_OFFSET (EXP_OFFSET)
  ) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_w),
    .exp_i  (m_q),
    .lock_o (lock_o)
  );
endmodule

// File: rtl/lockdet_checker.sv
module lockdet_checker #(
  parameter int unsigned FIELD_W    = 3,
  parameter int unsigned EXP_OFFSET = 13
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               lock_i,
  input logic               clr_i,
  input logic               miss_i,
  input logic               cfg_we_i,
  input logic [FIELD_W-1:0] field_new_i,
  input logic [FIELD_W-1:0] m_i
);
  localparam int unsigned SC_W = EXP_OFFSET + (1 << FIELD_W) + 1;

  logic [SC_W-1:0] since_q;
  logic [SC_W-1:0] win_w;

  assign win_w = SC_W'(1) << (32'(m_i) + EXP_OFFSET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             since_q <= '0;
    else if (clr_i)          since_q <= '0;
    else if (~&since_q)      since_q <= since_q + SC_W'(1);
  end

  assert_lock_at_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_i) |-> since_q == win_w);

  assert_lock_not_late_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_q > win_w) |-> lock_i);

  assert_miss_drops_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_i |=> !lock_i);

  assert_field_change_drops_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && field_new_i != m_i) |=> !lock_i);

  assert_same_field_keeps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && field_new_i == m_i && lock_i && !miss_i) |=> lock_i);

  assert_lock_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !clr_i) |=> lock_i);
endmodule

bind pll_lock_detector lockdet_checker #(
  .FIELD_W    (FIELD_W),
  .EXP_OFFSET (EXP_OFFSET)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lock_i      (lock_o),
  .clr_i       (clr_w),
  .miss_i      (miss_w),
  .cfg_we_i    (cfg_we_i),
  .field_new_i (field_new_w),
  .m_i         (m_q)
);

// File: tb/sim_pll_lock_detector.sv
`timescale 1ns/1ps
module sim_pll_lock_detector;
  localparam int TOL = 2;
  localparam int PER = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_p = 1'b0;
  logic       fb_p = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       lock;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  pll_lock_detector u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ref_pulse_i (ref_p),
    .fb_pulse_i  (fb_p),
    .cfg_we_i    (cfg_we),
    .cfg_i       (cfg),
    .lock_o      (lock)
  );

  // reference model: pending lone edge, its age, quiet time since last clear
  int  m_mdl = 6;
  bit  rp = 0, fp = 0;
  int  pend = 0;        // 0 none, 1 ref waiting for fb, 2 fb waiting for ref
  int  age = 0;
  bit  miss_prev = 0;
  longint quiet = 0;
  bit  exp_lock = 0;
  longint cyc = 0;
  longint wr_cyc = 0;
  longint rise_cyc = -1;
  bit  lock_prev = 0;

  always @(posedge clk) begin
    bit r, f, own, oth, clear, miss_now;
    cyc++;
    if (!rst_n) begin
      m_mdl = 6; rp = 0; fp = 0; pend = 0; age = 0;
      miss_prev = 0; quiet = 0; exp_lock = 0;
    end else begin
      r = ref_p && !rp;
      f = fb_p && !fp;
      rp = ref_p;
      fp = fb_p;
      clear = miss_prev || (cfg_we && int'(cfg[7:5]) != m_mdl);
      if (cfg_we) begin
        m_mdl = int'(cfg[7:5]);
        wr_cyc = cyc;
      end
      miss_now = 0;
      if (pend == 0) begin
        if (r && !f) begin pend = 1; age = 0; end
        else if (f && !r) begin pend = 2; age = 0; end
      end else begin
        own = (pend == 1) ? r : f;
        oth = (pend == 1) ? f : r;
        age++;
        if (own || age > TOL) begin miss_now = 1; pend = 0; end
        else if (oth) pend = 0;
      end
      miss_prev = miss_now;
      if (clear) quiet = 0;
      else if (quiet < (longint'(1) << (m_mdl + 13))) quiet++;
      exp_lock = (quiet >= (longint'(1) << (m_mdl + 13)));
    end
  end

  always @(negedge clk) begin
    bit e;
    e = rst_n ? exp_lock : 1'b0;
    total++;
    if (lock !== e) begin
      bad++;
      $display("FAIL %s cycle %0d: lock_o=%0b expected=%0b", cur_req, cyc, lock, e);
    end
    if (lock === 1'b1 && !lock_prev) rise_cyc = cyc;
    lock_prev = (lock === 1'b1);
  end

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pairs(int n, int gap, bit fb_first, int width);
    for (int p = 0; p < n; p++) begin
      for (int c = 0; c < PER; c++) begin
        bit a, b;
        @(negedge clk);
        a = (c < width);
        b = (c >= gap) && (c < gap + width);
        ref_p = fb_first ? b : a;
        fb_p  = fb_first ? a : b;
      end
    end
  endtask

  task automatic write_cfg(logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic double_ref();
    for (int c = 0; c < PER; c++) begin
      @(negedge clk);
      ref_p = (c == 0) || (c == 2);
      fb_p  = 1'b0;
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1 lock in reset", lock, 0);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 lock after release", lock, 0);

    // R6 + R2: change field to 0, aligned edges, window 8192
    cur_req = "R6";
    write_cfg(8'h15);
    chk("R6 lock after field write", lock, 0);
    cur_req = "R2";
    pairs(520, 0, 0, 1);
    chk("R2 locked with M=0", lock, 1);
    chk("R2 rise distance M=0", rise_cyc - wr_cyc, 8192);

    // R3: tolerance, both orders
    cur_req = "R3";
    pairs(20, TOL, 0, 1);
    chk("R3 ref leads by TOL", lock, 1);
    pairs(20, TOL, 1, 1);
    chk("R3 fb leads by TOL", lock, 1);

    // R9: wide pulses, offset 1
    cur_req = "R9";
    pairs(20, 1, 0, 3);
    chk("R9 wide pulses counted once", lock, 1);

    // R7: write same field, other bits differ
    cur_req = "R7";
    write_cfg(8'h0A);
    chk("R7 lock after same-field write", lock, 1);
    pairs(10, 0, 0, 1);
    chk("R7 lock kept", lock, 1);

    // R8: holds while aligned
    cur_req = "R8";
    pairs(200, 0, 1, 1);
    chk("R8 lock still held", lock, 1);

    // R6: field change while locked, then window 16384
    cur_req = "R6";
    write_cfg(8'h3F);
    chk("R6 field change drops lock", lock, 0);
    cur_req = "R2";
    pairs(1030, 0, 0, 1);
    chk("R2 locked with M=1", lock, 1);
    chk("R2 rise distance M=1", rise_cyc - wr_cyc, 16384);

    // R4: partner at TOL+1
    cur_req = "R4";
    pairs(1, TOL + 1, 0, 1);
    chk("R4 lock dropped", lock, 0);
    pairs(30, TOL + 1, 1, 1);
    chk("R4 stays unlocked", lock, 0);

    // relock at M=0, then R5
    cur_req = "R2";
    write_cfg(8'h00);
    pairs(520, 0, 0, 1);
    chk("R2 relocked M=0", lock, 1);
    chk("R2 rise distance relock", rise_cyc - wr_cyc, 8192);
    cur_req = "R5";
    double_ref();
    chk("R5 repeated ref drops lock", lock, 0);

    // M=2, window 32768
    cur_req = "R2";
    write_cfg(8'h40);
    pairs(2060, 0, 0, 1);
    chk("R2 locked with M=2", lock, 1);
    chk("R2 rise distance M=2", rise_cyc - wr_cyc, 32768);

    // R1: async reset while locked, field returns to 6
    cur_req = "R1";
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 chk("R1 async drop", lock, 0);
    repeat (2) @(negedge clk);
    #2 rst_n = 1'b1;
    pairs(600, 0, 0, 1);
    chk("R1 reset field is 6", lock, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule